// File: doc/BRIEF.md
# Power-Up Configuration Select Controller

This controller decides where the live register file of a programmable clock device gets its contents, both at power-up and later. When reset is released it captures three things: a mode strap, an address strap and two bank-select pins. A low mode strap hands the register file to the serial host, which may then rewrite it at any time. A high mode strap selects hardware mode. In hardware mode one of four stored configuration banks is copied into the live registers. The copy happens only when the stored enable-load bit of the chosen bank is set.

In hardware mode the select pins are ignored for a fixed startup window, counted in ticks of a timebase input. After the window the controller watches the synchronized pins. A change of exactly one pin reloads the newly chosen bank. Busy then stays high for a settle interval, during which further pin activity is dropped. A change of both pins in the same cycle is rejected, and a sticky error flag records it. The address strap picks one of two serial device addresses, so that two devices can share one bus.

The reset input is asserted asynchronously and is expected to be released synchronously to `clk` by the surrounding reset logic.

Top module: `cfg_select_ctrl`

## Requirements
- R1: While reset is held, busy_o is 1, and load_o, err_o and hw_mode_o are all 0.
- R2: hw_mode_o takes the level of mode_strap_i from the first clock after reset release (1 = hardware mode, 0 = host mode). Later changes of the strap have no effect until the next reset.
- R3: host_addr_o is 8'hD4 when addr_strap_i was 1 at the first clock after reset, and 8'hD0 when it was 0. The value is held until the next reset.
- R4: In hardware mode with load_en_i = 1, load_o pulses once, in the second cycle after reset release. During that pulse bank_o = {sel_i[1], sel_i[0]} as sampled at the first clock.
- R5: In hardware mode with load_en_i = 0 during the second cycle, no power-up load pulse is produced. bank_o still shows the sampled select value.
- R6: During the first WINDOW_TICKS timebase ticks after the boot cycle, select-pin changes cause no load, and bank_o does not change.
- R7: After the window, a change of exactly one select pin gives one load_o pulse, at most four cycles after the pin changes. bank_o carries the new {sel_i[1], sel_i[0]}.
- R8: After a pin-change load, busy_o stays 1 for SETTLE_TICKS ticks. Pin changes in that time cause no load and are never acted on later.
- R9: A change of both select pins in the same synchronized cycle causes no load and keeps bank_o. It sets err_o, which stays 1 until reset.
- R10: In host mode load_o never pulses, and busy_o is 0 from the second cycle after reset release onward.
- R11: load_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | Timebase tick, one-cycle pulse per time unit |
| mode_strap_i | input | 1 | Mode strap: 1 = hardware select, 0 = host owns registers |
| addr_strap_i | input | 1 | Serial address strap |
| sel_i | input | 2 | Bank select pins (asynchronous) |
| load_en_i | input | 1 | Enable-load bit read from the addressed stored bank |
| bank_o | output | 2 | Selected bank index |
| load_o | output | 1 | One-cycle copy strobe for bank_o |
| busy_o | output | 1 | Configuration load or settle in progress |
| hw_mode_o | output | 1 | Latched mode: 1 = hardware select |
| err_o | output | 1 | Sticky invalid dual-pin change flag |
| host_addr_o | output | 8 | Serial device address chosen by the strap |

## Verification
The assertions check, on every cycle, the properties of the outputs that never depend on the scenario. The load strobe lasts one cycle. Host mode never strobes. The error flag is sticky and never comes with a load. Outside busy periods, the bank index changes only together with a load strobe. The latched mode stays stable once busy has dropped. What the assertions cannot show is which pulses should occur. Only the bench scenarios can show that: the power-up load with its enable bit set or clear, the silence during the startup window, the single-pin reload and its latency, dropped changes during settle, the rejected dual-pin change, and the strap captures across several resets.

// File: rtl/cfg_sel_pkg.sv
package cfg_sel_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [2:0] {
    ST_LATCH  = 3'd0,
    ST_BOOT   = 3'd1,
    ST_WINDOW = 3'd2,
    ST_WATCH  = 3'd3,
    ST_SETTLE = 3'd4,
    ST_HOST   = 3'd5
  } cfg_state_e;
endpackage

// File: rtl/cfg_sel_sync.sv
module cfg_sel_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] sync_o,
  output logic         one_chg_o,
  output logic         multi_chg_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [W-1:0] diff;
  logic         diff_pow2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pins_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_comb begin
    diff        = sync_q ^ prev_q;
    diff_pow2   = ((diff & (diff - {{(W-1){1'b0}}, 1'b1})) == '0);
    one_chg_o   = (diff != '0) && diff_pow2;
    multi_chg_o = (diff != '0) && !diff_pow2;
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/cfg_interval_timer.sv
module cfg_interval_timer #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last;

  always_comb begin
    last   = (cnt_q == (limit_i - ONE));
    done_o = run_i && tick_i && last;
    if (!run_i || done_o) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = cnt_q + ONE;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/cfg_select_fsm.sv
module cfg_select_fsm
  import cfg_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_i,
  input  logic             addr_strap_i,
  input  logic [SEL_W-1:0] sel_raw_i,
  input  logic [SEL_W-1:0] sel_sync_i,
  input  logic             one_chg_i,
  input  logic             multi_chg_i,
  input  logic             load_en_i,
  input  logic             tmr_done_i,
  output logic             tmr_run_o,
  output logic             tmr_window_o,
  output logic [SEL_W-1:0] bank_o,
  output logic             load_o,
  output logic             busy_o,
  output logic             err_o,
  output logic             hw_mode_o,
  output logic             addr_hi_o
);
  cfg_state_e       state_q, state_d;
  logic             mode_q, mode_d;
  logic             addr_q, addr_d;
  logic [SEL_W-1:0] bank_q, bank_d;
  logic             load_q, load_d;
  logic             err_q, err_d;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    addr_d  = addr_q;
    bank_d  = bank_q;
    load_d  = 1'b0;
    err_d   = err_q;
    case (state_q)
      ST_LATCH: begin
        mode_d  = strap_i;
        addr_d  = addr_strap_i;
        bank_d  = sel_raw_i;
        state_d = ST_BOOT;
      end
      ST_BOOT: begin
        if (mode_q) begin
          load_d  = load_en_i;
          state_d = ST_WINDOW;
        end else begin
          state_d = ST_HOST;
        end
      end
      ST_WINDOW: begin
        if (tmr_done_i) state_d = ST_WATCH;
      end
      ST_WATCH: begin
        if (multi_chg_i) begin
          err_d = 1'b1;
        end else if (one_chg_i) begin
          bank_d  = sel_sync_i;
          load_d  = 1'b1;
          state_d = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (tmr_done_i) state_d = ST_WATCH;
      end
      ST_HOST: begin
        state_d = ST_HOST;
      end
      default: state_d = ST_LATCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LATCH;
      mode_q  <= 1'b0;
      addr_q  <= 1'b0;
      bank_q  <= '0;
      load_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      addr_q  <= addr_d;
      bank_q  <= bank_d;
      load_q  <= load_d;
      err_q   <= err_d;
    end
  end

  assign tmr_run_o    = (state_q == ST_WINDOW) || (state_q == ST_SETTLE);
  assign tmr_window_o = (state_q == ST_WINDOW);
  assign busy_o       = (state_q == ST_LATCH) || (state_q == ST_BOOT) ||
                        (state_q == ST_SETTLE);
  assign bank_o       = bank_q;
  assign load_o       = load_q;
  assign err_o        = err_q;
  assign hw_mode_o    = mode_q;
  assign addr_hi_o    = addr_q;
endmodule

// File: rtl/cfg_select_ctrl.sv
module cfg_select_ctrl
  import cfg_sel_pkg::*;
#(
  parameter int unsigned WINDOW_TICKS = 10000,
  parameter int unsigned SETTLE_TICKS = 1000,
  parameter logic [7:0]  ADDR_LO      = 8'hD0,
  parameter logic [7:0]  ADDR_HI      = 8'hD4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       mode_strap_i,
  input  logic       addr_strap_i,
  input  logic [1:0] sel_i,
  input  logic       load_en_i,
  output logic [1:0] bank_o,
  output logic       load_o,
  output logic       busy_o,
  output logic       hw_mode_o,
  output logic       err_o,
  output logic [7:0] host_addr_o
);
  localparam int unsigned MAX_TICKS = (WINDOW_TICKS > SETTLE_TICKS) ? WINDOW_TICKS : SETTLE_TICKS;
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);
  localparam logic [CNT_W-1:0] WIN_LIM = CNT_W'(WINDOW_TICKS);
  localparam logic [CNT_W-1:0] SET_LIM = CNT_W'(SETTLE_TICKS);

  logic [SEL_W-1:0] sel_sync;
  logic             one_chg, multi_chg;
  logic             tmr_run, tmr_window, tmr_done;
  logic [CNT_W-1:0] tmr_limit;
  logic             addr_hi;

  cfg_sel_sync #(.W(SEL_W)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pins_i     (sel_i),
    .sync_o     (sel_sync),
    .one_chg_o  (one_chg),
    .multi_chg_o(multi_chg)
  );

  assign tmr_limit = tmr_window ? WIN_LIM : SET_LIM;

  cfg_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (tmr_run),
    .tick_i (tick_i),
    .limit_i(tmr_limit),
    .done_o (tmr_done)
  );

  cfg_select_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_i     (mode_strap_i),
    .addr_strap_i(addr_strap_i),
    .sel_raw_i   (sel_i),
    .sel_sync_i  (sel_sync),
    .one_chg_i   (one_chg),
    .multi_chg_i (multi_chg),
    .load_en_i   (load_en_i),
    .tmr_done_i  (tmr_done),
    .tmr_run_o   (tmr_run),
    .tmr_window_o(tmr_window),
    .bank_o      (bank_o),
    .load_o      (load_o),
    .busy_o      (busy_o),
    .err_o       (err_o),
    .hw_mode_o   (hw_mode_o),
    .addr_hi_o   (addr_hi)
  );

  assign host_addr_o = addr_hi ? ADDR_HI : ADDR_LO;
endmodule

// File: rtl/cfg_select_checker.sv
module cfg_select_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bank_o,
  input logic       load_o,
  input logic       busy_o,
  input logic       hw_mode_o,
  input logic       err_o
);
  AST_LOAD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o); // R11

  AST_HOST_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_mode_o |-> !load_o); // R10

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o); // R9

  AST_ERR_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !load_o); // R9

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> $stable(hw_mode_o)); // R2

  AST_BANK_MOVES_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> (load_o || $stable(bank_o))); // R7
endmodule

bind cfg_select_ctrl cfg_select_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bank_o   (bank_o),
  .load_o   (load_o),
  .busy_o   (busy_o),
  .hw_mode_o(hw_mode_o),
  .err_o    (err_o)
);

// File: tb/tb_cfg_select_ctrl.sv
module tb_cfg_select_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       mode_strap_i = 1'b0;
  logic       addr_strap_i = 1'b0;
  logic [1:0] sel_i = 2'b00;
  logic       load_en_i = 1'b0;
  logic [1:0] bank_o;
  logic       load_o, busy_o, hw_mode_o, err_o;
  logic [7:0] host_addr_o;

  int errors = 0;
  int checks = 0;
  logic [1:0] exp_q[$];

  cfg_select_ctrl #(.WINDOW_TICKS(16), .SETTLE_TICKS(6)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .mode_strap_i(mode_strap_i),
    .addr_strap_i(addr_strap_i), .sel_i(sel_i), .load_en_i(load_en_i),
    .bank_o(bank_o), .load_o(load_o), .busy_o(busy_o), .hw_mode_o(hw_mode_o),
    .err_o(err_o), .host_addr_o(host_addr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick_i = ~tick_i;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_load(input logic [1:0] b);
    exp_q.push_back(b);
  endtask

  // monitor: every load pulse must match the next expected bank
  always @(negedge clk) begin
    if (rst_n && load_o) begin
      if (exp_q.size() == 0) begin
        chk("R6/R8/R9/R10 unexpected load", {30'd0, bank_o}, 32'hFFFF);
      end else begin
        chk("R4/R7 load bank", {30'd0, bank_o}, {30'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic strap, input logic addr, input logic [1:0] sel,
                          input logic en);
    @(negedge clk);
    rst_n = 1'b0;
    mode_strap_i = strap;
    addr_strap_i = addr;
    sel_i = sel;
    load_en_i = en;
    cycles(3);
    chk("R1 busy in reset", {31'd0, busy_o}, 32'd1);
    chk("R1 load in reset", {31'd0, load_o}, 32'd0);
    chk("R1 err in reset", {31'd0, err_o}, 32'd0);
    chk("R1 mode in reset", {31'd0, hw_mode_o}, 32'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // Scenario A: hardware mode, bank 2, power-up load enabled, high address
    expect_load(2'd2);
    do_reset(1'b1, 1'b1, 2'd2, 1'b1);
    cycles(3);
    chk("R2 hw mode latched", {31'd0, hw_mode_o}, 32'd1);
    chk("R3 address high", {24'd0, host_addr_o}, 32'hD4);
    chk("R4 boot load seen", exp_q.size(), 32'd0);
    // change inside startup window: ignored
    sel_i = 2'd3;
    cycles(50);
    chk("R6 bank kept after window", {30'd0, bank_o}, 32'd2);
    // single-pin change 3 -> 1
    expect_load(2'd1);
    sel_i = 2'd1;
    cycles(4);
    chk("R7 reload seen", exp_q.size(), 32'd0);
    chk("R8 busy in settle", {31'd0, busy_o}, 32'd1);
    sel_i = 2'd0;             // during settle: dropped
    cycles(30);
    chk("R8 busy released", {31'd0, busy_o}, 32'd0);
    chk("R8 change in settle dropped", {30'd0, bank_o}, 32'd1);
    // dual change 0 -> 3
    sel_i = 2'd3;
    cycles(10);
    chk("R9 err set", {31'd0, err_o}, 32'd1);
    chk("R9 bank kept", {30'd0, bank_o}, 32'd1);
    // single change 3 -> 2
    expect_load(2'd2);
    sel_i = 2'd2;
    cycles(25);
    chk("R7 bank after second reload", {30'd0, bank_o}, 32'd2);
    chk("R9 err sticky", {31'd0, err_o}, 32'd1);
    mode_strap_i = 1'b0;
    cycles(5);
    chk("R2 strap change ignored", {31'd0, hw_mode_o}, 32'd1);
    chk("R7 all loads seen", exp_q.size(), 32'd0);

    // Scenario B: hardware mode, enable-load clear, low address
    do_reset(1'b1, 1'b0, 2'd1, 1'b0);
    cycles(5);
    chk("R5 bank shown without load", {30'd0, bank_o}, 32'd1);
    chk("R3 address low", {24'd0, host_addr_o}, 32'hD0);
    chk("R1 err cleared by reset", {31'd0, err_o}, 32'd0);

    // Scenario C: host mode
    do_reset(1'b0, 1'b0, 2'd2, 1'b1);
    cycles(5);
    chk("R10 host mode", {31'd0, hw_mode_o}, 32'd0);
    chk("R10 busy low", {31'd0, busy_o}, 32'd0);
    cycles(60);
    sel_i = 2'd3;
    cycles(20);
    chk("R10 no load in host mode", {30'd0, bank_o}, 32'd2);
    chk("R10 busy stays low", {31'd0, busy_o}, 32'd0);
    chk("R4 queue empty at end", exp_q.size(), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule